// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block supplies the address sequence for a four-beat memory burst. On a clock edge where the clock enable is active and the advance control is low, it captures a complete starting address from its input. On each later edge where the clock enable is active and the advance control is high, it moves to the next beat of the burst. Only the two least significant address bits change from beat to beat. The upper bits keep the value that was loaded.

A strap input selects the beat order. In linear order the low bits count upward modulo four from the loaded offset. In interleaved order the low bits are the loaded offset XORed with the beat number. In both orders the fourth advance returns to the starting address, and further advances repeat the same cycle. When the clock enable is inactive (high), every input is ignored and the state is held. The strap is expected to be tied and left unchanged, so it is only moved while the block is held in reset.

The control is a two-state machine. ST_EMPTY is the state after reset, before any address has been loaded. ST_BURST means a burst is active. LOAD moves the machine from ST_EMPTY or ST_BURST into ST_BURST, with beat 0 at the new address. STEP keeps the machine in ST_BURST and moves it one beat on. HOLD leaves everything as it is when the clock enable is high. IDLE-ADVANCE is an advance taken in ST_EMPTY; it changes nothing. Reset returns the machine to ST_EMPTY.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after its release, burst_addr is 0 and loaded is 0.
- R2: An edge with cke_n=0 and adv_n=0 captures ld_addr. From the next cycle on, burst_addr equals that address (beat 0) and loaded is 1.
- R3: With order_sel=0 (linear), each edge with cke_n=0 and adv_n=1 in a burst sets burst_addr[1:0] to its previous value plus 1 modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: With order_sel=1 (interleaved), after k advances burst_addr[1:0] equals start XOR k. A start of 01 gives 01, 00, 11, 10. A start of 10 gives 10, 11, 00, 01.
- R5: After four advances burst_addr equals the loaded start address again, and the sequence repeats.
- R6: An advance never changes burst_addr bits above bit 1.
- R7: An edge with cke_n=1 changes neither burst_addr nor loaded, whatever the values of adv_n and ld_addr.
- R8: An advance (cke_n=0, adv_n=1) in ST_EMPTY leaves burst_addr at 0 and loaded at 0.
- R9: A load while a burst is active restarts at beat 0 at the new address. The next advance then steps from the new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; when high, all state is held |
| adv_n | input | 1 | Low: load ld_addr; high: advance one beat |
| order_sel | input | 1 | Strap: 0 selects linear order, 1 selects interleaved order |
| ld_addr | input | AW (20) | Starting address captured on a load |
| burst_addr | output | AW (20) | Current burst address |
| loaded | output | 1 | High in ST_BURST, after a load |

## Verification
The bench targets several corner cases:
- Odd start offsets in both orders. This is where linear and interleaved order differ, so a design that used the wrong order would produce 10 instead of 00 after a start of 01.
- A carry out of bit 1 in linear order. A design that let this carry reach the upper bits would corrupt the row address at the wrap.
- Loads and advances taken while the clock enable is high. A design that sampled adv_n or ld_addr during hold would jump to a new address.
- A reload in the middle of a burst. A design that did not clear the beat count would continue from a stale beat.
- Advances taken before any load. A design that counted in ST_EMPTY would report a nonzero address from reset.

A long stretch of pseudo-random stimulus in both orders is compared on every clock against a behavioural model.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_BURST = 1'b1
    } burst_state_t;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int BEAT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 step,
    output logic [BEAT_BITS-1:0] beat
);

    localparam logic [BEAT_BITS-1:0] LAST_BEAT = {BEAT_BITS{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (clr) begin
            beat <= '0;
        end else if (step) begin
            beat <= beat + 1'b1;
        end
    end

    // R5: the beat count returns to zero after the last beat
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && beat == LAST_BEAT) |=> (beat == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int BEAT_BITS = 2
) (
    input  logic                 order_sel,
    input  logic [BEAT_BITS-1:0] start_off,
    input  logic [BEAT_BITS-1:0] beat,
    output logic [BEAT_BITS-1:0] low_out
);

    logic [BEAT_BITS-1:0] lin_off;
    logic [BEAT_BITS-1:0] ilv_off;

    assign lin_off = start_off + beat;

    for (genvar b = 0; b < BEAT_BITS; b++) begin : g_ilv
        assign ilv_off[b] = start_off[b] ^ beat[b];
    end

    always_comb begin
        if (order_sel) begin
            low_out = ilv_off;
        end else begin
            low_out = lin_off;
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int AW        = 20,
    parameter int BEAT_BITS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_n,
    input  logic          adv_n,
    input  logic          order_sel,
    input  logic [AW-1:0] ld_addr,
    output logic [AW-1:0] burst_addr,
    output logic          loaded
);
    import burst_pkg::*;

    localparam int UPPER_W = AW - BEAT_BITS;

    burst_state_t         state;
    burst_state_t         state_nx;
    logic [AW-1:0]        base_q;
    logic [BEAT_BITS-1:0] beat;
    logic [BEAT_BITS-1:0] low_bits;
    logic                 load_ev;
    logic                 step_ev;

    assign load_ev = !cke_n && !adv_n;
    assign step_ev = !cke_n && adv_n && (state == ST_BURST);

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (load_ev) state_nx = ST_BURST;
            ST_BURST: state_nx = ST_BURST;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // start address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_ev) begin
            base_q <= ld_addr;
        end
    end

    burst_beat_ctr #(.BEAT_BITS(BEAT_BITS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_ev),
        .step  (step_ev),
        .beat  (beat)
    );

    burst_order_map #(.BEAT_BITS(BEAT_BITS)) u_map (
        .order_sel (order_sel),
        .start_off (base_q[BEAT_BITS-1:0]),
        .beat      (beat),
        .low_out   (low_bits)
    );

    // output process
    always_comb begin
        loaded     = (state == ST_BURST);
        burst_addr = {base_q[AW-1:BEAT_BITS], low_bits};
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_n) |=> (burst_addr == $past(ld_addr) && loaded));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_n && loaded && !order_sel) |=>
        (burst_addr[BEAT_BITS-1:0] ==
         BEAT_BITS'($past(burst_addr[BEAT_BITS-1:0]) + 1'b1)));

    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_n) |=>
        (burst_addr[AW-1:BEAT_BITS] == $past(burst_addr[AW-1:BEAT_BITS])));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(burst_addr) && $stable(loaded)));

    assert_empty_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!loaded && adv_n) |=> (!loaded && burst_addr == '0));

    initial begin
        assert_width_ok: assert (UPPER_W > 0);
    end

endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [AW-1:0] burst_addr;
    logic          loaded;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural model
    int m_base = 0;
    int m_cnt = 0;
    bit m_loaded = 0;
    bit m_order = 0;

    always #10 clk = ~clk;

    burst_addr_gen #(.AW(AW), .BEAT_BITS(2)) u_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv_n(adv_n),
        .order_sel(order_sel), .ld_addr(ld_addr),
        .burst_addr(burst_addr), .loaded(loaded)
    );

    function automatic int model_addr();
        int s, low;
        if (!m_loaded) return 0;
        s = m_base % 4;
        if (m_order) low = s ^ m_cnt;
        else low = (s + m_cnt) % 4;
        return (m_base - s) + low;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit ord, input string tag);
        @(negedge clk);
        rst_n = 1'b0; cke_n = 1'b1; adv_n = 1'b1; order_sel = ord;
        m_order = ord; m_base = 0; m_cnt = 0; m_loaded = 0;
        @(posedge clk); @(posedge clk); #2;
        check({tag, " addr in reset"}, int'(burst_addr), 0);
        check({tag, " loaded in reset"}, int'(loaded), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check({tag, " addr after release"}, int'(burst_addr), 0);
    endtask

    task automatic tick(input bit ck, input bit av, input int a, input string tag);
        @(negedge clk);
        cke_n = ck; adv_n = av; ld_addr = AW'(a);
        @(posedge clk);
        if (!ck) begin
            if (!av) begin
                m_base = a; m_cnt = 0; m_loaded = 1;
            end else if (m_loaded) begin
                m_cnt = (m_cnt + 1) % 4;
            end
        end
        #2;
        check({tag, " addr"}, int'(burst_addr), model_addr());
        check({tag, " loaded"}, int'(loaded), int'(m_loaded));
    endtask

    task automatic low_is(input int exp, input string tag);
        check(tag, int'(burst_addr[1:0]), exp);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lfsr;
        // R1 reset, linear order
        do_reset(1'b0, "R1");
        // R8 advance before any load
        tick(1'b0, 1'b1, 'h12345, "R8 idle advance");
        tick(1'b0, 1'b1, 'h0, "R8 idle advance 2");
        // R2 load, R3 linear, R5 wrap, R6 upper fixed
        tick(1'b0, 1'b0, 'h5A3C1, "R2 load");
        check("R2 full addr", int'(burst_addr), 'h5A3C1);
        tick(1'b0, 1'b1, 'hFFFFF, "R3 beat1"); low_is(2, "R3 lin 01->10");
        tick(1'b0, 1'b1, 'h0, "R3 beat2");     low_is(3, "R3 lin ->11");
        tick(1'b0, 1'b1, 'h0, "R6 carry beat3"); low_is(0, "R3 lin ->00");
        check("R6 upper after carry", int'(burst_addr[AW-1:2]), 'h5A3C1 >> 2);
        tick(1'b0, 1'b1, 'h0, "R5 wrap");
        check("R5 back to start", int'(burst_addr), 'h5A3C1);
        // R7 hold ignores load and advance
        tick(1'b1, 1'b0, 'hABCDE, "R7 hold load");
        tick(1'b1, 1'b1, 'h11111, "R7 hold adv");
        check("R7 still start", int'(burst_addr), 'h5A3C1);
        // R9 reload mid-burst
        tick(1'b0, 1'b1, 'h0, "R9 pre");
        tick(1'b0, 1'b0, 'h2468B, "R9 reload");
        tick(1'b0, 1'b1, 'h0, "R9 step");
        low_is(0, "R9 lin 11->00");

        // interleaved order
        do_reset(1'b1, "R1 ilv");
        tick(1'b0, 1'b0, 'hC0DE1, "R4 load 01");
        tick(1'b0, 1'b1, 'h0, "R4 a"); low_is(0, "R4 ilv 01 beat1");
        tick(1'b0, 1'b1, 'h0, "R4 b"); low_is(3, "R4 ilv 01 beat2");
        tick(1'b0, 1'b1, 'h0, "R4 c"); low_is(2, "R4 ilv 01 beat3");
        tick(1'b0, 1'b1, 'h0, "R5 ilv wrap");
        check("R5 ilv back to start", int'(burst_addr), 'hC0DE1);
        tick(1'b0, 1'b0, 'h3F00A, "R4 load 10");
        tick(1'b0, 1'b1, 'h0, "R4 d"); low_is(3, "R4 ilv 10 beat1");
        tick(1'b1, 1'b0, 'h77777, "R7 ilv hold");
        tick(1'b0, 1'b1, 'h0, "R4 e"); low_is(0, "R4 ilv 10 beat2");
        tick(1'b0, 1'b1, 'h0, "R4 f"); low_is(1, "R4 ilv 10 beat3");
        check("R6 ilv upper", int'(burst_addr[AW-1:2]), 'h3F00A >> 2);

        // pseudo-random stretches, both orders (R2..R9 via model)
        lfsr = 32'h1ACE5EED;
        for (int seg = 0; seg < 2; seg++) begin
            do_reset(seg[0], "R1 rnd");
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                tick(lfsr[3:0] == 4'd0, lfsr[6:4] != 3'd0, lfsr[27:8], "R6 rnd");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule